// File: doc/BRIEF.md
# Selectable Frequency Output Divider

This block turns a 32.768 kHz reference clock into a square wave whose rate is chosen by a 4-bit select code. It serves fifteen rates: 32768, 4096, 1024 and 64 Hz, then every power of two from 32 Hz down to 1/32 Hz. The output pin is active low and rests high whenever the output is off. The select code normally comes from a control register loaded by a host over a serial bus.

All divided rates are taken from one 20-bit counter. That counter restarts whenever a new code is applied. A requested code is not applied at once. It is held back until the wave now on the pin has finished its full period. As a result the pin never shows a shortened high or low phase. The fastest setting gates the reference clock straight to the pin.

Top module: `freq_out_divider`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) makes the applied code 0. The output reads high in the cycle that follows.
- R2: While the applied code is 0, the output stays high.
- R3: Codes 2, 3 and 4 give a square wave with a period of 8, 32 and 512 reference cycles. A code c from 5 to 15 gives a period of 2^(c+5) cycles. These codes stand for 4096, 1024 and 64 Hz, and then 32 Hz halving down to 1/32 Hz.
- R4: Each period of a divided code (2 to 15) starts with a low half and ends with a high half, each of exactly half the period (50 percent duty).
- R5: While the applied code is 1, the output is the inverse of the reference clock: low while the clock is high and high while it is low.
- R6: During a divided code, the select input is sampled only at the clock edge that ends the current output period. The code sampled there takes effect at once, with a fresh period starting on its low half. While the applied code is 0 or 1, the select input is sampled at every edge.
- R7: A select value that appears and goes away between two period ends has no effect on the output.
- R8: A reset asserted in the middle of a period returns the output to high at once. The next select code then takes effect at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 4 | Requested frequency code (0 = off) |
| fout_n | output | 1 | Active-low frequency output, high when off |

## Verification
A wrong applied code or a wrong count shows up on fout_n as an edge at the wrong place. The bench checks the pin at every falling clock edge against a period model, so such a fault is caught within one reference cycle of the first wrong edge. A code applied too early cuts the current period short, and the bench sees this on the cycle the new low half starts. A code applied too late keeps the old wave for one half period too long. For the pass-through code, the pin is also sampled while the clock is high, so an inverted or stuck pass path fails in its first cycle.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  // Counter bit whose value forms the wave for a divided code.
  // Codes 2..4 sit on sparse taps, codes 5..15 on consecutive taps
  // ending at the top bit of the chain.
  function automatic int tap_of(input int code, input int div_w);
    int t;
    case (code)
      2:       t = div_w - 18;
      3:       t = div_w - 16;
      4:       t = div_w - 12;
      default: t = div_w - 16 + code;
    endcase
    if (code < 2) t = 0;
    return t;
  endfunction

endpackage

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl #(
  parameter int SEL_W = 4,
  parameter int DIV_W = 20,
  localparam int TAP_W = $clog2(DIV_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_req,
  input  logic [DIV_W-1:0] cnt,
  output logic [SEL_W-1:0] sel_q,
  output logic [TAP_W-1:0] tap_idx,
  output logic             boundary
);
  import fdiv_pkg::*;

  localparam logic [DIV_W-1:0] ALL_ONES = '1;

  logic [DIV_W-1:0] last_cnt;
  int               tap_int;

  always_comb begin
    tap_int  = tap_of(int'(sel_q), DIV_W);
    tap_idx  = TAP_W'(tap_int);
    last_cnt = ALL_ONES >> (DIV_W - 1 - tap_int);
  end

  // Codes 0 and 1 have no period to finish; others wait for the last count.
  assign boundary = (sel_q <= SEL_W'(1)) || (cnt == last_cnt);

  always_ff @(posedge clk) begin
    if (rst)           sel_q <= '0;
    else if (boundary) sel_q <= sel_req;
  end

endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter #(
  parameter int DIV_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [DIV_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else                cnt <= cnt + DIV_W'(1);
  end

endmodule

// File: rtl/fdiv_outmux.sv
module fdiv_outmux #(
  parameter int SEL_W = 4,
  parameter int DIV_W = 20,
  localparam int TAP_W = $clog2(DIV_W)
) (
  input  logic             clk,
  input  logic [SEL_W-1:0] sel_q,
  input  logic [TAP_W-1:0] tap_idx,
  input  logic [DIV_W-1:0] cnt,
  output logic             fout_n
);

  always_comb begin
    if (sel_q == '0)               fout_n = 1'b1;
    else if (sel_q == SEL_W'(1))   fout_n = ~clk;
    else                           fout_n = cnt[tap_idx];
  end

endmodule

// File: rtl/freq_out_divider.sv
module freq_out_divider #(
  parameter int SEL_W = 4,
  parameter int DIV_W = 20,
  localparam int TAP_W = $clog2(DIV_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             fout_n
);

  logic [SEL_W-1:0] sel_q;
  logic [TAP_W-1:0] tap_idx;
  logic [DIV_W-1:0] cnt;
  logic             boundary;

  fdiv_ctrl #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst(rst), .sel_req(sel), .cnt(cnt),
    .sel_q(sel_q), .tap_idx(tap_idx), .boundary(boundary)
  );

  fdiv_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(boundary), .cnt(cnt)
  );

  fdiv_outmux #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_out (
    .clk(clk), .sel_q(sel_q), .tap_idx(tap_idx), .cnt(cnt), .fout_n(fout_n)
  );

endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker #(
  parameter int SEL_W = 4,
  parameter int DIV_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic [SEL_W-1:0] sel_q,
  input logic [DIV_W-1:0] cnt,
  input logic             fout_n
);

  // R1: first cycle after reset is idle with a cleared chain
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_q == '0 && cnt == '0));

  // R2: an applied zero code keeps the pin high
  p_off_high_r2: assert property (@(posedge clk) disable iff (rst)
    (sel_q == '0) |-> fout_n);

  // R4: inside a period the chain advances by exactly one
  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> (cnt == $past(cnt) + DIV_W'(1)));

  // R6: codes without a period keep the chain parked at zero
  p_idle_parked_r6: assert property (@(posedge clk) disable iff (rst)
    (sel_q <= SEL_W'(1)) |-> (cnt == '0));

  // R7: the applied code never moves in the middle of a period
  p_no_midswitch_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> $stable(sel_q));

endmodule

bind freq_out_divider fdiv_checker #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .sel_q(sel_q), .cnt(cnt), .fout_n(fout_n)
);

// File: tb/tb_freq_out_divider.sv
module tb_freq_out_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] sel = 4'd0;
  logic       fout_n;

  int checks = 0;
  int failures = 0;
  bit chk_en = 1'b0;
  string phase = "R1";

  int m_code = 0;
  int m_pos = 0;

  freq_out_divider dut (.clk(clk), .rst(rst), .sel(sel), .fout_n(fout_n));

  always #5 clk = ~clk;

  // Half period in reference cycles for a divided code (from R3)
  function automatic int half_len(input int c);
    case (c)
      2:       return 4;
      3:       return 16;
      4:       return 256;
      default: return 1 << (c + 4);
    endcase
  endfunction

  // Period model built from R1, R6, R8
  always @(posedge clk) begin
    if (rst) begin
      m_code = 0;
      m_pos = 0;
    end else if (m_code <= 1 || m_pos == 2 * half_len(m_code) - 1) begin
      m_code = int'(sel);
      m_pos = 0;
    end else begin
      m_pos = m_pos + 1;
    end
  end

  // Low phase of the clock: R2 off, R5 pass high, R4 halves
  always @(negedge clk) begin
    if (chk_en) begin
      logic exp_v;
      string tag;
      if (m_code == 0)      begin exp_v = 1'b1; tag = "R2"; end
      else if (m_code == 1) begin exp_v = 1'b1; tag = "R5"; end
      else begin
        exp_v = (m_pos < half_len(m_code)) ? 1'b0 : 1'b1;
        tag = "R4";
      end
      checks++;
      if (fout_n !== exp_v) begin
        failures++;
        $display("FAIL %s/%s code=%0d pos=%0d actual=%b expected=%b",
                 tag, phase, m_code, m_pos, fout_n, exp_v);
      end
    end
  end

  // High phase of the clock under the pass-through code (R5)
  always @(posedge clk) begin
    #2;
    if (chk_en && m_code == 1) begin
      checks++;
      if (fout_n !== 1'b0) begin
        failures++;
        $display("FAIL R5/%s clock-high actual=%b expected=0", phase, fout_n);
      end
    end
  end

  task automatic hold(input int code, input int n);
    sel = 4'(code);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4711);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_en = 1'b1;
    phase = "R1";
    hold(0, 4);
    phase = "R3_4096";  hold(2, 40);
    phase = "R3_1024";  hold(3, 100);
    phase = "R5_pass";  hold(1, 12);
    phase = "R3_64";    hold(4, 1100);
    phase = "R6_random";
    for (int i = 0; i < 300; i++) begin
      hold(int'($urandom_range(0, 6)), int'($urandom_range(1, 400)));
    end
    phase = "R7_glitch";
    hold(4, 600);
    hold(6, 40);
    hold(4, 1200);
    phase = "R3_1Hz";   hold(10, 33000);
    phase = "R6_slow";  hold(15, 5000);
    hold(2, 10000);
    phase = "R8_reset";
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    hold(2, 40);
    phase = "R2_off";   hold(0, 20);
    chk_en = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog phase=%s actual=running expected=done", phase);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule